// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block sits between a microcontroller bus and a byte-wide flash array model. It decodes the standard single-supply flash command sequence from bus writes and runs three operations: programming one byte, erasing one sector, and erasing the whole main array. Each operation lasts a fixed number of clock cycles, set by a parameter, and the `busy` output is high for that whole time. The array edit itself is issued in the final busy cycle.

While an operation runs, a read of the main array returns a status byte instead of array data. Software can wait for completion in either of two ways. It can poll bit 7, which differs from the final data until the operation is done. It can also watch bit 6, which inverts on every status read until the operation is done. A separate boot region, selected by the top address bit, keeps returning its own data throughout, so code can run from it while the main array is busy. Unlock offsets are compared on the low 11 address bits, so `MAIN_AW` must be at least 11.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `bus_dout` is 0x00, and the decoder is in read mode.
- R2: The writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by a data write at any main address, start a byte program. `busy` rises after the data write's clock edge and stays high for exactly `PROG_CYC` cycles.
- R3: A program stores the bitwise AND of the old byte and the written byte, so bits can only go from 1 to 0.
- R4: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA, followed by 0x30 at any address, erase the sector holding that address. The sector is chosen by the top `SECT_W` bits of the main address. Every byte of that sector becomes 0xFF and all other bytes keep their values. `busy` lasts `SERA_CYC` cycles.
- R5: The same erase prefix followed by 0x10@0x555 sets every main byte to 0xFF. `busy` lasts `CHIP_CYC` cycles.
- R6: While `busy` is high, a main-array read returns in bit 7 the inverse of bit 7 of the byte being programmed, or 0 during an erase. Once `busy` is low, reads return the stored data.
- R7: While `busy` is high, bit 6 of a main-array read inverts on every such read, starting from 0 at the first one after reset. Bits 5..0 of such a read are 0.
- R8: A read with address bit `MAIN_AW` set returns `boot_rdata` for `boot_addr` one cycle later, whether or not the block is busy. Writes to that region are not commands.
- R9: Any write whose data or offset does not match the next expected step, including 0xF0, returns the decoder to read mode. A later data write then programs nothing.
- R10: Bus writes made while `busy` is high are ignored and do not advance the command sequence.
- R11: `bus_dout` is registered. It changes only in the cycle after a read strobe and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | MAIN_AW+1 | Bus address; the top bit selects the boot region |
| bus_din | input | 8 | Bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_dout | output | 8 | Registered read data |
| busy | output | 1 | High while an operation runs |
| arr_addr | output | MAIN_AW | Main array address (the bus address, or the operation address in the final cycle) |
| arr_rdata | input | 8 | Array read data at `arr_addr`, combinational |
| arr_we | output | 1 | Byte write pulse for the array |
| arr_wdata | output | 8 | Byte written to the array |
| arr_erase | output | 1 | Erase pulse for the array |
| arr_erase_all | output | 1 | When `arr_erase` is high: erase the whole array instead of one sector |
| arr_sector | output | SECT_W | Sector index to erase |
| boot_addr | output | BOOT_AW | Boot memory address |
| boot_rdata | input | 8 | Boot memory read data, combinational |

## Verification
A decoder stuck in a wrong state shows up at the first data write after a sequence. The byte is programmed when it should not be, or not programmed when it should be, and `busy` differs from the expected value right after that write's edge. An off-by-one in the operation counter moves the fall of `busy` by one cycle, which the window checks catch at the exact edge. A wrong status byte or toggle state is visible on the very next busy read. A lost or misdirected array edit shows up on the first readback after `busy` falls.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_UNLK1,
        CMD_UNLK2,
        CMD_PROG,
        CMD_ERS1,
        CMD_ERS2,
        CMD_ERS3
    } cmd_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_e;

    localparam int OFS_W = 11;
    localparam logic [OFS_W-1:0] OFS_A = 11'h555;
    localparam logic [OFS_W-1:0] OFS_B = 11'h2AA;

    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] VERB_PROG  = 8'hA0;
    localparam logic [7:0] VERB_ERASE = 8'h80;
    localparam logic [7:0] VERB_SECT  = 8'h30;
    localparam logic [7:0] VERB_CHIP  = 8'h10;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int MAIN_AW = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [MAIN_AW-1:0] addr,
    input  logic [7:0]         din,
    output logic               start,
    output op_kind_e           start_kind
);

    typedef struct packed {
        cmd_state_e st;
    } seq_t;

    seq_t s_d, s_q;
    logic is_a, is_b;

    assign is_a = (addr[OFS_W-1:0] == OFS_A);
    assign is_b = (addr[OFS_W-1:0] == OFS_B);

    always_comb begin
        s_d        = s_q;
        start      = 1'b0;
        start_kind = OP_NONE;
        if (wr_ok) begin
            s_d.st = CMD_READ;
            unique case (s_q.st)
                CMD_READ:  if (is_a && din == KEY_A) s_d.st = CMD_UNLK1;
                CMD_UNLK1: if (is_b && din == KEY_B) s_d.st = CMD_UNLK2;
                CMD_UNLK2: begin
                    if (is_a && din == VERB_PROG)  s_d.st = CMD_PROG;
                    if (is_a && din == VERB_ERASE) s_d.st = CMD_ERS1;
                end
                CMD_PROG: begin
                    start      = 1'b1;
                    start_kind = OP_PROG;
                end
                CMD_ERS1: if (is_a && din == KEY_A) s_d.st = CMD_ERS2;
                CMD_ERS2: if (is_b && din == KEY_B) s_d.st = CMD_ERS3;
                CMD_ERS3: begin
                    if (din == VERB_SECT) begin
                        start      = 1'b1;
                        start_kind = OP_SECT;
                    end else if (is_a && din == VERB_CHIP) begin
                        start      = 1'b1;
                        start_kind = OP_CHIP;
                    end
                end
                default: s_d.st = CMD_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: CMD_READ};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int MAIN_AW  = 17,
    parameter int PROG_CYC = 8,
    parameter int SERA_CYC = 40,
    parameter int CHIP_CYC = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  op_kind_e           start_kind,
    input  logic [MAIN_AW-1:0] start_addr,
    input  logic [7:0]         start_data,
    output logic               busy,
    output logic               done,
    output op_kind_e           kind,
    output logic [MAIN_AW-1:0] op_addr,
    output logic [7:0]         op_data
);

    localparam int MAX_A  = (PROG_CYC > SERA_CYC) ? PROG_CYC : SERA_CYC;
    localparam int MAX_C  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        logic               busy;
        op_kind_e           kind;
        logic [CNT_W-1:0]   cnt;
        logic [MAIN_AW-1:0] addr;
        logic [7:0]         data;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d  = e_q;
        done = e_q.busy && (e_q.cnt == '0);
        if (done) begin
            e_d.busy = 1'b0;
            e_d.kind = OP_NONE;
        end else if (e_q.busy) begin
            e_d.cnt = e_q.cnt - 1'b1;
        end else if (start) begin
            e_d.busy = 1'b1;
            e_d.kind = start_kind;
            e_d.addr = start_addr;
            e_d.data = start_data;
            unique case (start_kind)
                OP_PROG: e_d.cnt = CNT_W'(PROG_CYC - 1);
                OP_SECT: e_d.cnt = CNT_W'(SERA_CYC - 1);
                default: e_d.cnt = CNT_W'(CHIP_CYC - 1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '{busy: 1'b0, kind: OP_NONE, cnt: '0, addr: '0, data: '0};
        else        e_q <= e_d;
    end

    assign busy    = e_q.busy;
    assign kind    = e_q.kind;
    assign op_addr = e_q.addr;
    assign op_data = e_q.data;

endmodule

// File: rtl/flash_read_port.sv
module flash_read_port
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       boot_sel,
    input  logic       busy,
    input  op_kind_e   kind,
    input  logic       op_bit7,
    input  logic [7:0] arr_rdata,
    input  logic [7:0] boot_rdata,
    output logic [7:0] dout
);

    typedef struct packed {
        logic [7:0] dout;
        logic       tog;
    } rdp_t;

    rdp_t r_d, r_q;
    logic poll_bit;

    assign poll_bit = (kind == OP_PROG) ? ~op_bit7 : 1'b0;

    always_comb begin
        r_d = r_q;
        if (rd) begin
            if (boot_sel) begin
                r_d.dout = boot_rdata;
            end else if (busy) begin
                r_d.dout = {poll_bit, r_q.tog, 6'b0};
                r_d.tog  = ~r_q.tog;
            end else begin
                r_d.dout = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{dout: 8'h00, tog: 1'b0};
        else        r_q <= r_d;
    end

    assign dout = r_q.dout;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int MAIN_AW  = 17,
    parameter int SECT_W   = 3,
    parameter int BOOT_AW  = 15,
    parameter int PROG_CYC = 8,
    parameter int SERA_CYC = 40,
    parameter int CHIP_CYC = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAIN_AW:0]   bus_addr,
    input  logic [7:0]         bus_din,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [7:0]         bus_dout,
    output logic               busy,
    output logic [MAIN_AW-1:0] arr_addr,
    input  logic [7:0]         arr_rdata,
    output logic               arr_we,
    output logic [7:0]         arr_wdata,
    output logic               arr_erase,
    output logic               arr_erase_all,
    output logic [SECT_W-1:0]  arr_sector,
    output logic [BOOT_AW-1:0] boot_addr,
    input  logic [7:0]         boot_rdata
);

    logic               boot_sel, wr_ok, start, done;
    op_kind_e           start_kind, kind;
    logic [MAIN_AW-1:0] op_addr;
    logic [7:0]         op_data;

    assign boot_sel  = bus_addr[MAIN_AW];
    assign wr_ok     = bus_wr && !boot_sel && !busy;
    assign boot_addr = bus_addr[BOOT_AW-1:0];

    flash_cmd_seq #(.MAIN_AW(MAIN_AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .addr       (bus_addr[MAIN_AW-1:0]),
        .din        (bus_din),
        .start      (start),
        .start_kind (start_kind)
    );

    flash_op_engine #(
        .MAIN_AW  (MAIN_AW),
        .PROG_CYC (PROG_CYC),
        .SERA_CYC (SERA_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .start_addr (bus_addr[MAIN_AW-1:0]),
        .start_data (bus_din),
        .busy       (busy),
        .done       (done),
        .kind       (kind),
        .op_addr    (op_addr),
        .op_data    (op_data)
    );

    flash_read_port u_rdp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (bus_rd),
        .boot_sel   (boot_sel),
        .busy       (busy),
        .kind       (kind),
        .op_bit7    (op_data[7]),
        .arr_rdata  (arr_rdata),
        .boot_rdata (boot_rdata),
        .dout       (bus_dout)
    );

    assign arr_addr      = done ? op_addr : bus_addr[MAIN_AW-1:0];
    assign arr_we        = done && (kind == OP_PROG);
    assign arr_wdata     = op_data & arr_rdata;
    assign arr_erase     = done && (kind != OP_PROG) && (kind != OP_NONE);
    assign arr_erase_all = (kind == OP_CHIP);
    assign arr_sector    = op_addr[MAIN_AW-1 -: SECT_W];

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
    parameter int MAIN_AW = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MAIN_AW:0] bus_addr,
    input logic             bus_rd,
    input logic [7:0]       bus_dout,
    input logic             busy,
    input logic             arr_we,
    input logic             arr_erase,
    input logic [7:0]       boot_rdata
);

    AST_EDIT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || arr_erase) |-> busy);                                       // R2

    AST_BUSY_ENDS_WITH_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(arr_we || arr_erase));                           // R2

    AST_SINGLE_EDIT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we && arr_erase));                                               // R4

    AST_BOOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[MAIN_AW]) |=> (bus_dout == $past(boot_rdata)));    // R8

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[MAIN_AW] && busy) |=> (bus_dout[5:0] == 6'b0));   // R7

    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_dout));                                        // R11

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.MAIN_AW(MAIN_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_dout   (bus_dout),
    .busy       (busy),
    .arr_we     (arr_we),
    .arr_erase  (arr_erase),
    .boot_rdata (boot_rdata)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

    localparam int AW   = 12;
    localparam int SW   = 3;
    localparam int BW   = 10;
    localparam int PCYC = 8;
    localparam int SCYC = 20;
    localparam int CCYC = 30;
    localparam int MSZ  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW:0]   bus_addr = '0;
    logic [7:0]    bus_din = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_dout;
    logic          busy;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_rdata;
    logic          arr_we, arr_erase, arr_erase_all;
    logic [7:0]    arr_wdata;
    logic [SW-1:0] arr_sector;
    logic [BW-1:0] boot_addr;
    logic [7:0]    boot_rdata;

    int checks = 0;
    int fails  = 0;
    logic tog_m = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];
    logic rd_seen = 1'b0;

    logic [7:0] mem [MSZ];

    always #10 clk = ~clk;

    flash_cmd_ctrl #(
        .MAIN_AW(AW), .SECT_W(SW), .BOOT_AW(BW),
        .PROG_CYC(PCYC), .SERA_CYC(SCYC), .CHIP_CYC(CCYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dout(bus_dout), .busy(busy),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .arr_erase(arr_erase), .arr_erase_all(arr_erase_all),
        .arr_sector(arr_sector), .boot_addr(boot_addr), .boot_rdata(boot_rdata)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] boot_val(logic [BW-1:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    assign arr_rdata  = mem[arr_addr];
    assign boot_rdata = boot_val(boot_addr);

    initial for (int i = 0; i < MSZ; i++) mem[i] = init_val(i);

    always @(posedge clk) begin
        if (arr_we) mem[arr_addr] <= arr_wdata;
        if (arr_erase)
            for (int i = 0; i < MSZ; i++)
                if (arr_erase_all || (i >> (AW - SW)) == int'(arr_sector)) mem[i] <= 8'hFF;
        rd_seen <= bus_rd;
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard actual=%h expected=none", bus_dout);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(bus_dout, it.exp, it.tag);
            end
        end
    end

    task automatic wr(input logic [AW:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_din = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        @(negedge clk);
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // status read while busy; models the toggle bit
    task automatic rd_status(input logic [AW:0] a, input logic b7, input string tag);
        rd(a, {b7, tog_m, 6'b0}, tag);
        tog_m = ~tog_m;
    endtask

    task automatic unlock;
        wr(13'h555, 8'hAA);
        wr(13'h2AA, 8'h55);
    endtask

    task automatic prog(input logic [AW:0] a, input logic [7:0] d);
        unlock(); wr(13'h555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_pre;
        unlock(); wr(13'h555, 8'h80); unlock();
    endtask

    // called right after the starting write; checks the exact busy length
    task automatic busy_window(input int n, input string tag);
        check({7'b0, busy}, 8'h01, {tag, " busy rises"});
        repeat (n - 1) @(negedge clk);
        check({7'b0, busy}, 8'h01, {tag, " busy last cycle"});
        @(negedge clk);
        check({7'b0, busy}, 8'h00, {tag, " busy falls"});
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({7'b0, busy}, 8'h00, "R1 busy after reset");
        check(bus_dout, 8'h00, "R1 dout after reset");

        // R11: plain read, dout holds afterwards
        rd(13'h123, init_val('h123), "R11 main read");
        repeat (3) @(negedge clk);
        check(bus_dout, init_val('h123), "R11 dout holds");

        // R1: decoder starts in read mode: a lone data write programs nothing
        wr(13'h040, 8'h00);
        check({7'b0, busy}, 8'h00, "R1 no op from read mode");
        rd(13'h040, init_val('h040), "R1 byte unchanged");

        // R2: program timing
        prog(13'h100, 8'h0F);
        busy_window(PCYC, "R2 program");
        // R3: AND with old value (0x5A & 0x0F)
        rd(13'h100, 8'h0A, "R3 program result");

        // R6/R7: status polling during a program with bit7 = 1
        prog(13'h201, 8'hF0);
        rd_status(13'h201, 1'b0, "R6 R7 status read 1");
        rd_status(13'h777, 1'b0, "R7 status read 2");
        // R8: boot read while busy
        rd(13'h1000 | 13'h03C, boot_val(10'h03C), "R8 boot during busy");
        // R10: a full sequence while busy is ignored
        unlock(); wr(13'h555, 8'hA0);
        wait_idle();
        wr(13'h300, 8'h00);
        check({7'b0, busy}, 8'h00, "R10 ignored while busy");
        rd(13'h300, init_val('h300), "R10 byte unchanged");
        rd(13'h201, init_val('h201) & 8'hF0, "R6 true data after done");

        // R6: data polling bit 7 inverted for a bit7=0 byte
        prog(13'h0F5, 8'h01);
        rd_status(13'h0F5, 1'b1, "R6 poll bit7");
        wait_idle();

        // R9: bad data in the sequence
        unlock(); wr(13'h555, 8'h77); wr(13'h555, 8'hA0); wr(13'h050, 8'h00);
        check({7'b0, busy}, 8'h00, "R9 bad verb");
        rd(13'h050, init_val('h050), "R9 byte unchanged");
        // R9: F0 reset mid-sequence
        wr(13'h555, 8'hAA); wr(13'h2AA, 8'hF0); wr(13'h555, 8'hA0); wr(13'h051, 8'h00);
        check({7'b0, busy}, 8'h00, "R9 F0 abort");
        // R9: wrong offset
        wr(13'h555, 8'hAA); wr(13'h2AB, 8'h55); wr(13'h555, 8'hA0); wr(13'h052, 8'h00);
        check({7'b0, busy}, 8'h00, "R9 wrong offset");
        rd(13'h052, init_val('h052), "R9 byte unchanged 2");

        // R4: sector erase of sector 1 (0x200..0x3FF)
        erase_pre(); wr(13'h250, 8'h30);
        busy_window(SCYC, "R4 sector erase");
        rd(13'h200, 8'hFF, "R4 sector start");
        rd(13'h3FF, 8'hFF, "R4 sector end");
        rd(13'h1FF, init_val('h1FF), "R4 below sector");
        rd(13'h400, init_val('h400), "R4 above sector");
        rd(13'h100, 8'h0A, "R4 earlier program kept");

        // R6: erase status bit7 = 0
        erase_pre(); wr(13'hA00, 8'h30);
        rd_status(13'h000, 1'b0, "R6 erase status");
        wait_idle();
        rd(13'hBFF, 8'hFF, "R4 sector 5 erased");

        // R8: boot read while idle; writes to boot are not commands
        rd(13'h1000 | 13'h155, boot_val(10'h155), "R8 boot idle");
        wr(13'h1555, 8'hAA); wr(13'h2AA, 8'h55); wr(13'h555, 8'hA0); wr(13'h060, 8'h00);
        check({7'b0, busy}, 8'h00, "R8 boot write not command");

        // R5: chip erase
        erase_pre(); wr(13'h555, 8'h10);
        busy_window(CCYC, "R5 chip erase");
        rd(13'h000, 8'hFF, "R5 first byte");
        rd(13'hFFF, 8'hFF, "R5 last byte");
        rd(13'h123, 8'hFF, "R5 middle byte");

        repeat (3) @(negedge clk);
        check(8'(sb.size()), 8'h00, "R11 scoreboard drained");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule